// File: doc/BRIEF.md
# Serial Key Combination Lock

This block controls access through a secret code entered one bit at a time. A stored combination of `KEY_LEN` bits (three by default) is presented on `combo_i`. The operator starts by pressing the clear button (`rst_btn_i`). For each digit, the operator sets the key switch (`key_i`) and presses the enter button (`enter_i`). Each press compares the switch against the next combination bit. Bit 0 of `combo_i` is compared first.

A wrong digit does not stop entry. The machine moves to a spoiled path that still accepts the remaining digits. Only after the last digit does it report a verdict: `unlock_o` if every digit matched, or `error_o` if any digit differed. Each verdict is held until the next clear.

The enter button is turned into a single-cycle press pulse inside the block, so a held button counts once. Between presses the machine idles and ignores the key switch.

Top module: `serial_lock`

## Requirements
- R1: While `rst_btn_i` is high, and in the first cycle after it is released, `unlock_o` and `error_o` are both 0.
- R2: The n-th press (n = 0, 1, 2) compares `key_i` with `combo_i[n]`, as sampled on the clock edge where the press is seen. Digit n is therefore checked against bit n of `combo_i`, and a later change of an already compared bit has no effect.
- R3: A press is a 0-to-1 change of `enter_i` between consecutive clock edges. Holding `enter_i` high counts as one press. Changes of `key_i` without a press have no effect.
- R4: If all `KEY_LEN` digits match, `unlock_o` goes to 1 on the clock edge that registers the last press.
- R5: If any digit differs, `error_o` goes to 1 on the clock edge that registers the last press. Before that press, both outputs stay 0, even after a mismatch.
- R6: `unlock_o` and `error_o` are never 1 at the same time.
- R7: Once a verdict is shown, it holds and further presses are ignored until `rst_btn_i` is asserted.
- R8: Asserting `rst_btn_i` from any state, including a verdict, returns the machine to the first digit with both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_btn_i | input | 1 | Operator clear, synchronous, active high |
| enter_i | input | 1 | Enter button level |
| key_i | input | 1 | Key switch bit |
| combo_i | input | KEY_LEN | Stored combination, bit 0 compared first |
| unlock_o | output | 1 | Combination accepted |
| error_o | output | 1 | Combination rejected |

## Verification
The assertions assume that `rst_btn_i` is held for at least one clock edge before any check applies. They also assume that `enter_i` and `key_i` are synchronous to the clock, so a press is judged from the levels registered on consecutive edges.

The stimulus changes every input only at the falling edge. It always begins a run with a clear. It spaces presses by at least one low cycle of `enter_i`, except in the directed case that holds the button across several edges while toggling the key.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        LK_COLLECT = 2'd0,
        LK_SPOILED = 2'd1,
        LK_OPEN    = 2'd2,
        LK_REJECT  = 2'd3
    } lock_state_e;

    function automatic logic is_verdict(lock_state_e s);
        return (s == LK_OPEN) || (s == LK_REJECT);
    endfunction

endpackage

// File: rtl/lock_press_detect.sv
module lock_press_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic press_o
);

    typedef struct packed {
        logic prev;
    } det_regs_t;

    det_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = level_i;
    end

    // The previous level is tracked even during clear, so a button held
    // through clear does not count as a press once clear is released.
    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign press_o = level_i & ~r_q.prev;

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        press_o |=> !press_o); // R3

endmodule

// File: rtl/lock_bit_select.sv
module lock_bit_select #(
    parameter int KEY_LEN = 3,
    localparam int IDX_W  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic [KEY_LEN-1:0] combo_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               key_i,
    output logic               match_o
);

    logic [KEY_LEN-1:0] hit;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_digit
        assign hit[g] = (idx_i == IDX_W'(g)) & ~(key_i ^ combo_i[g]);
    end

    assign match_o = |hit;

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter int KEY_LEN = 3,
    localparam int IDX_W  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1,
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             press_i,
    input  logic             match_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             unlock_o,
    output logic             error_o
);

    typedef struct packed {
        lock_state_e      state;
        logic [IDX_W-1:0] idx;
        logic             unlock;
        logic             error;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            LK_COLLECT, LK_SPOILED: begin
                if (press_i) begin
                    if (r_q.idx == LAST_IDX) begin
                        if (r_q.state == LK_COLLECT && match_i) begin
                            r_d.state  = LK_OPEN;
                            r_d.unlock = 1'b1;
                        end else begin
                            r_d.state = LK_REJECT;
                            r_d.error = 1'b1;
                        end
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        if (!match_i) begin
                            r_d.state = LK_SPOILED;
                        end
                    end
                end
            end
            LK_OPEN, LK_REJECT: begin
                r_d = r_q;
            end
            default: begin
                r_d.state = LK_COLLECT;
            end
        endcase
        if (rst_i) begin
            r_d.state  = LK_COLLECT;
            r_d.idx    = '0;
            r_d.unlock = 1'b0;
            r_d.error  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign idx_o    = r_q.idx;
    assign unlock_o = r_q.unlock;
    assign error_o  = r_q.error;

    AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (rst_i)
        !(unlock_o && error_o)); // R6

    AST_CLEAR_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!unlock_o && !error_o && idx_o == '0)); // R8

    AST_VERDICT_ON_PRESS: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(unlock_o) || $rose(error_o)) |-> ($past(press_i) && $past(idx_o) == LAST_IDX)); // R5

    AST_VERDICT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (unlock_o || error_o) |=> ($stable(unlock_o) && $stable(error_o))); // R7

    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_o <= LAST_IDX); // R2

    AST_VERDICT_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
        (unlock_o || error_o) |-> is_verdict(r_q.state)); // R4

endmodule

// File: rtl/serial_lock.sv
module serial_lock #(
    parameter int KEY_LEN = 3,
    localparam int IDX_W  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic               clk_i,
    input  logic               rst_btn_i,
    input  logic               enter_i,
    input  logic               key_i,
    input  logic [KEY_LEN-1:0] combo_i,
    output logic               unlock_o,
    output logic               error_o
);

    logic             press;
    logic             match;
    logic [IDX_W-1:0] idx;

    lock_press_detect u_press (
        .clk_i  (clk_i),
        .rst_i  (rst_btn_i),
        .level_i(enter_i),
        .press_o(press)
    );

    lock_bit_select #(.KEY_LEN(KEY_LEN)) u_select (
        .combo_i(combo_i),
        .idx_i  (idx),
        .key_i  (key_i),
        .match_o(match)
    );

    lock_fsm #(.KEY_LEN(KEY_LEN)) u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_btn_i),
        .press_i (press),
        .match_i (match),
        .idx_o   (idx),
        .unlock_o(unlock_o),
        .error_o (error_o)
    );

endmodule

// File: tb/serial_lock_tb.sv
module serial_lock_tb;

    localparam int KL = 3;

    logic          clk = 1'b0;
    logic          rst_btn = 1'b1;
    logic          enter = 1'b0;
    logic          key = 1'b0;
    logic [KL-1:0] combo = '0;
    logic          unlock, error;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_lock #(.KEY_LEN(KL)) u_dut (
        .clk_i(clk), .rst_btn_i(rst_btn), .enter_i(enter), .key_i(key),
        .combo_i(combo), .unlock_o(unlock), .error_o(error)
    );

    function automatic logic [1:0] expect_out(logic [KL-1:0] c, logic [KL-1:0] k);
        return (c == k) ? 2'b10 : 2'b01;
    endfunction

    task automatic check(string req, logic [1:0] exp);
        checks++;
        if ({unlock, error} !== exp) begin
            fails++;
            $display("FAIL %s: {unlock,error} actual=%b expected=%b", req, {unlock, error}, exp);
        end
    endtask

    task automatic clear();
        @(negedge clk);
        rst_btn = 1'b1;
        enter   = 1'b0;
        @(negedge clk);
        check("R1", 2'b00);
        @(negedge clk);
        rst_btn = 1'b0;
        @(negedge clk);
        check("R1", 2'b00);
    endtask

    task automatic press(logic k, int hold);
        @(negedge clk);
        key   = k;
        enter = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            key = ~key;
        end
        @(negedge clk);
        enter = 1'b0;
    endtask

    task automatic run(logic [KL-1:0] c, logic [KL-1:0] k);
        combo = c;
        for (int i = 0; i < KL; i++) begin
            press(k[i], 0);
            if (i < KL - 1) check("R5", 2'b00);
        end
        check((c == k) ? "R4" : "R5", expect_out(c, k));
    endtask

    initial begin
        logic [KL-1:0] c, k;
        void'($urandom(32'd20240611));
        clear();

        // Directed: exact match
        run(3'b101, 3'b101);
        press(1'b0, 0);
        check("R7", 2'b10);
        clear();

        // Directed: mismatch on the first digit only
        run(3'b110, 3'b111);
        press(1'b1, 0);
        check("R7", 2'b01);
        clear();

        // Directed: order of digits, reversed key must fail
        run(3'b001, 3'b100);
        clear();

        // Directed: held enter with toggling key counts as one press
        combo = 3'b000;
        press(1'b0, 5);
        check("R3", 2'b00);
        press(1'b0, 0);
        check("R3", 2'b00);
        press(1'b0, 0);
        check("R3", 2'b10);
        clear();

        // Directed: combo bit changed after being compared has no effect
        combo = 3'b011;
        press(1'b1, 0);
        combo = 3'b010;
        press(1'b1, 0);
        press(1'b0, 0);
        check("R2", 2'b10);
        clear();

        // Directed: clear in the middle of entry
        combo = 3'b111;
        press(1'b0, 0);
        press(1'b1, 0);
        clear();
        run(3'b111, 3'b111);
        clear();
        check("R8", 2'b00);

        // Random
        for (int t = 0; t < 60; t++) begin
            c = KL'($urandom);
            k = c;
            for (int b = 0; b < KL; b++)
                if ($urandom % 4 == 0) k[b] = ~k[b];
            run(c, k);
            if (($urandom % 2) == 1) begin
                press(KL == 0 ? 1'b0 : 1'b1, 0);
                check("R7", expect_out(c, k));
            end
            clear();
        end

        done = 1'b1;
    end

    always @(negedge clk) begin
        if (unlock && error) begin
            checks++;
            fails++;
            $display("FAIL R6: {unlock,error} actual=11 expected=not 11");
        end
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule